// File: doc/BRIEF.md
# ADC Interrupt Vector Generator

This block collects the completion flags of sixteen result slots plus two overflow events (a result overwritten before it was read, and a conversion that ran out of time), masks each with its own enable and with a global enable input, and reduces them to one prioritised vector word. Software reads that word and jumps through a table. Every vector value is even, so the word can be used directly as a byte offset into a table of 16-bit entries. While any source is pending and enabled, the vector is nonzero and the interrupt request is high.

The sequencer raises flags through one-cycle set inputs. A small register port lets software program the enables, inspect and write the flags, and read the vector. A read of the vector that returns an overflow code acknowledges that overflow. A read of a result slot, signalled on a separate strobe, clears that slot's flag. When a set and a clear hit the same flag in the same cycle, the set wins, so no event is lost.

Top module: `adc_ivec`

## Requirements
- R1: After reset, all flags and enables are 0, every register reads 0, and `irq_o` is low.
- R2: When `gie_i` is low, the vector reads 0x0000 whatever flags and enables hold. When no enabled flag is pending, the vector also reads 0x0000.
- R3: An enabled, pending result-overflow flag gives vector 0x0002. It outranks every other source.
- R4: An enabled, pending time-overflow flag gives vector 0x0004. It outranks every slot flag.
- R5: An enabled, pending slot flag n gives vector 0x0006 + 2n, so slot 15 gives 0x0024. The lowest pending slot index wins.
- R6: Bit n of the slot-enable register gates slot n. Control register bit 0 enables the result-overflow source and bit 1 enables the time-overflow source. A disabled flag is still recorded and still readable.
- R7: A vector read (`reg_rd_i` at address 3) that returns 0x0002 or 0x0004 clears that overflow flag on the same clock edge. A vector read never changes slot flags.
- R8: A pulse on `slot_rd_i` clears only the flag of slot `slot_rd_idx_i`. A write to the slot-flag register loads it, so a 0 clears a bit and a 1 sets it.
- R9: A set input wins over a read-clear, an acknowledge or a register write to the same flag in the same cycle.
- R10: `irq_o` is high exactly when the vector is nonzero.
- R11: The register map is: address 0 is slot enables; address 1 is slot flags; address 2 is control, with bit 0 the result-overflow enable, bit 1 the time-overflow enable, bit 2 the result-overflow flag and bit 3 the time-overflow flag; address 3 is the vector. Address 3 is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global interrupt enable |
| slot_set_i | input | NSLOT | Per-slot completion set pulses from the sequencer |
| ovf_set_i | input | 1 | Result-overflow set pulse |
| tov_set_i | input | 1 | Time-overflow set pulse |
| slot_rd_i | input | 1 | Result slot read strobe |
| slot_rd_idx_i | input | IDX_W | Index of the slot being read |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; takes read side effects |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
The critical overlap is a vector read that acknowledges an overflow on the same edge that the sequencer raises that overflow again. The bench holds `ovf_set_i` during the acknowledging read. It then checks that the read returned 0x0002 and that the flag is still set afterwards. Only a second, undisturbed read is expected to clear the flag and move the vector to the next source. The same overlap is provoked for a slot read-clear that coincides with a set of the same slot, and the bench checks that the flag survives.

// File: rtl/adc_ivec_pkg.sv
package adc_ivec_pkg;
  typedef enum logic [1:0] {
    ADDR_SLOT_EN  = 2'd0,
    ADDR_SLOT_FLG = 2'd1,
    ADDR_CTRL     = 2'd2,
    ADDR_VEC      = 2'd3
  } reg_addr_e;

  localparam int unsigned VEC_OVF       = 2;
  localparam int unsigned VEC_TOV       = 4;
  localparam int unsigned VEC_SLOT_BASE = 6;

  localparam int unsigned CTRL_OVF_EN  = 0;
  localparam int unsigned CTRL_TOV_EN  = 1;
  localparam int unsigned CTRL_OVF_FLG = 2;
  localparam int unsigned CTRL_TOV_FLG = 3;
endpackage

// File: rtl/ivec_flags.sv
module ivec_flags #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;     // set wins
      else if (wr_i)      q_o[g] <= wdata_i[g];
      else if (clr_i[g])  q_o[g] <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> q_o[g]);
    a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g] && !wr_i) |=> !q_o[g]);
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[g] && !set_i[g] && !wr_i) |=> $stable(q_o[g]));
  end
endmodule

// File: rtl/ivec_prio.sv
module ivec_prio
  import adc_ivec_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic             ovf_flg_i,
  input  logic             ovf_en_i,
  input  logic             tov_flg_i,
  input  logic             tov_en_i,
  input  logic [NSLOT-1:0] slot_flg_i,
  input  logic [NSLOT-1:0] slot_en_i,
  output logic [DW-1:0]    vec_o
);
  localparam int unsigned NSRC = NSLOT + 2;

  logic [NSLOT-1:0] slot_pend;
  logic [NSRC-1:0]  gnt;
  logic             found;

  assign slot_pend = slot_flg_i & slot_en_i;

  always_comb begin
    gnt   = '0;
    vec_o = '0;
    found = 1'b0;
    if (gie_i) begin
      if (ovf_flg_i && ovf_en_i) begin
        gnt[0] = 1'b1;
        vec_o  = DW'(VEC_OVF);
      end else if (tov_flg_i && tov_en_i) begin
        gnt[1] = 1'b1;
        vec_o  = DW'(VEC_TOV);
      end else begin
        for (int i = 0; i < NSLOT; i++) begin
          if (slot_pend[i] && !found) begin
            found    = 1'b1;
            gnt[i+2] = 1'b1;
            vec_o    = DW'(VEC_SLOT_BASE + 2 * i);
          end
        end
      end
    end
  end

  a_r2_gie_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> (vec_o == '0));
  a_r5_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));
  a_r3_ovf_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && ovf_flg_i && ovf_en_i) |-> (vec_o == DW'(VEC_OVF)));
  a_r5_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[0] == 1'b0);
endmodule

// File: rtl/adc_ivec.sv
module adc_ivec
  import adc_ivec_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned IDX_W = $clog2(NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic [NSLOT-1:0] slot_set_i,
  input  logic             ovf_set_i,
  input  logic             tov_set_i,
  input  logic             slot_rd_i,
  input  logic [IDX_W-1:0] slot_rd_idx_i,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  logic [NSLOT-1:0] slot_en_q, slot_flg, slot_clr;
  logic             ovf_en_q, tov_en_q;
  logic [1:0]       xov_flg, xov_clr;
  logic [DW-1:0]    vec;
  logic             wr_en, wr_flg, wr_ctrl, rd_vec;

  assign wr_en   = reg_wr_i && (reg_addr_i == ADDR_SLOT_EN);
  assign wr_flg  = reg_wr_i && (reg_addr_i == ADDR_SLOT_FLG);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign rd_vec  = reg_rd_i && (reg_addr_i == ADDR_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_en_q <= '0;
      ovf_en_q  <= 1'b0;
      tov_en_q  <= 1'b0;
    end else begin
      if (wr_en) slot_en_q <= reg_wdata_i[NSLOT-1:0];
      if (wr_ctrl) begin
        ovf_en_q <= reg_wdata_i[CTRL_OVF_EN];
        tov_en_q <= reg_wdata_i[CTRL_TOV_EN];
      end
    end
  end

  always_comb begin
    slot_clr = '0;
    if (slot_rd_i) slot_clr[slot_rd_idx_i] = 1'b1;
  end

  // bit 0: result overflow, bit 1: time overflow
  assign xov_clr[0] = rd_vec && (vec == DW'(VEC_OVF));
  assign xov_clr[1] = rd_vec && (vec == DW'(VEC_TOV));

  ivec_flags #(.N(NSLOT)) u_slot_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (slot_set_i),
    .clr_i   (slot_clr),
    .wr_i    (wr_flg),
    .wdata_i (reg_wdata_i[NSLOT-1:0]),
    .q_o     (slot_flg)
  );

  ivec_flags #(.N(2)) u_xov_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({tov_set_i, ovf_set_i}),
    .clr_i   (xov_clr),
    .wr_i    (wr_ctrl),
    .wdata_i ({reg_wdata_i[CTRL_TOV_FLG], reg_wdata_i[CTRL_OVF_FLG]}),
    .q_o     (xov_flg)
  );

  ivec_prio #(.NSLOT(NSLOT), .DW(DW)) u_prio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gie_i      (gie_i),
    .ovf_flg_i  (xov_flg[0]),
    .ovf_en_i   (ovf_en_q),
    .tov_flg_i  (xov_flg[1]),
    .tov_en_i   (tov_en_q),
    .slot_flg_i (slot_flg),
    .slot_en_i  (slot_en_q),
    .vec_o      (vec)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_SLOT_EN:  reg_rdata_o[NSLOT-1:0] = slot_en_q;
      ADDR_SLOT_FLG: reg_rdata_o[NSLOT-1:0] = slot_flg;
      ADDR_CTRL: begin
        reg_rdata_o[CTRL_OVF_EN]  = ovf_en_q;
        reg_rdata_o[CTRL_TOV_EN]  = tov_en_q;
        reg_rdata_o[CTRL_OVF_FLG] = xov_flg[0];
        reg_rdata_o[CTRL_TOV_FLG] = xov_flg[1];
      end
      default:       reg_rdata_o = vec;
    endcase
  end

  assign irq_o = |vec;

  a_r7_ovf_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec && reg_rdata_o == DW'(VEC_OVF) && !ovf_set_i && !wr_ctrl) |=> !xov_flg[0]);
  a_r7_tov_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec && reg_rdata_o == DW'(VEC_TOV) && !tov_set_i && !wr_ctrl) |=> !xov_flg[1]);
  a_r7_slots_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec && !slot_rd_i && !wr_flg) |=> ($past(slot_flg) & ~slot_flg) == '0);
  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_VEC) |-> (irq_o == (reg_rdata_o != '0)));
endmodule

// File: tb/adc_ivec_bench.sv
module adc_ivec_bench;
  localparam int NSLOT = 16;
  localparam int DW    = 16;
  localparam int NTBL  = 10;

  logic clk = 1'b0, rst_n = 1'b0, gie = 1'b0;
  logic [NSLOT-1:0] slot_set = '0;
  logic ovf_set = 1'b0, tov_set = 1'b0, slot_rd = 1'b0;
  logic [3:0] slot_idx = '0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0, rdata;
  logic irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_ivec #(.NSLOT(NSLOT), .DW(DW)) u_adc_ivec (
    .clk_i(clk), .rst_ni(rst_n), .gie_i(gie), .slot_set_i(slot_set),
    .ovf_set_i(ovf_set), .tov_set_i(tov_set), .slot_rd_i(slot_rd),
    .slot_rd_idx_i(slot_idx), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {slot_en, slot_flags, ctrl[3:0], gie, expected vector}
  localparam logic [52:0] TBL [NTBL] = '{
    {16'hFFFF, 16'h0000, 4'b0000, 1'b1, 16'h0000},  // R2 nothing pending
    {16'hFFFF, 16'h0001, 4'b0000, 1'b1, 16'h0006},  // R5 slot 0
    {16'hFFFF, 16'h8000, 4'b0000, 1'b1, 16'h0024},  // R5 slot 15
    {16'hFFFF, 16'h8010, 4'b0000, 1'b1, 16'h000E},  // R5 lowest wins
    {16'hFFEF, 16'h8010, 4'b0000, 1'b1, 16'h0024},  // R6 slot 4 masked
    {16'hFFFF, 16'h0001, 4'b0111, 1'b1, 16'h0002},  // R3 overflow first
    {16'hFFFF, 16'h0001, 4'b1010, 1'b1, 16'h0004},  // R4 time overflow
    {16'hFFFF, 16'h0000, 4'b0100, 1'b1, 16'h0000},  // R6 ovf not enabled
    {16'hFFFF, 16'hFFFF, 4'b1111, 1'b0, 16'h0000},  // R2 gie low
    {16'hFFFF, 16'h0000, 4'b1110, 1'b1, 16'h0004}   // R6 ovf masked, tov wins
  };

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #2;
    d = rdata;
  endtask

  task automatic rd_vec(output logic [DW-1:0] v);
    @(negedge clk);
    addr = 2'd3; rd = 1'b1;
    #2;
    v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], d);
      chk("R1 reset reg", d, '0);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'd0);

    // R2..R6 vector table
    for (int i = 0; i < NTBL; i++) begin
      wr_reg(2'd0, TBL[i][52:37]);
      wr_reg(2'd1, TBL[i][36:21]);
      wr_reg(2'd2, {12'd0, TBL[i][20:17]});
      gie = TBL[i][16];
      peek(2'd3, d);
      chk($sformatf("R5 table %0d vector", i), d, TBL[i][15:0]);
      chk($sformatf("R10 table %0d irq", i), {15'd0, irq}, {15'd0, (TBL[i][15:0] != 0)});
    end

    // R6 disabled flag still recorded
    wr_reg(2'd2, 16'h0004);
    peek(2'd2, d);
    chk("R6 flag kept while disabled", d, 16'h0004);

    // R7 ack by vector read, slots untouched
    gie = 1'b1;
    wr_reg(2'd1, 16'h0022);
    wr_reg(2'd2, 16'h000F);
    rd_vec(d);
    chk("R7 first read ovf", d, 16'h0002);
    peek(2'd2, d);
    chk("R7 ovf flag cleared", d, 16'h000B);
    rd_vec(d);
    chk("R7 second read tov", d, 16'h0004);
    peek(2'd3, d);
    chk("R7 vector moves to slot 1", d, 16'h0008);
    rd_vec(d);
    peek(2'd1, d);
    chk("R7 slot flags kept", d, 16'h0022);

    // R8 slot read clears that slot only
    @(negedge clk);
    slot_idx = 4'd1; slot_rd = 1'b1;
    @(negedge clk);
    slot_rd = 1'b0;
    peek(2'd1, d);
    chk("R8 slot 1 cleared", d, 16'h0020);
    peek(2'd3, d);
    chk("R8 vector slot 5", d, 16'h0010);

    // R9 set wins over read-clear
    @(negedge clk);
    slot_idx = 4'd5; slot_rd = 1'b1; slot_set = 16'h0020;
    @(negedge clk);
    slot_rd = 1'b0; slot_set = '0;
    peek(2'd1, d);
    chk("R9 slot set beats read", d, 16'h0020);

    // R9 set wins over vector acknowledge
    @(negedge clk);
    ovf_set = 1'b1;
    @(negedge clk);
    ovf_set = 1'b0;
    @(negedge clk);
    addr = 2'd3; rd = 1'b1; ovf_set = 1'b1;
    #2;
    chk("R9 read during set returns ovf", rdata, 16'h0002);
    @(negedge clk);
    rd = 1'b0; ovf_set = 1'b0;
    peek(2'd2, d);
    chk("R9 ovf survives ack", d, 16'h0007);
    rd_vec(d);
    chk("R7 undisturbed ack read", d, 16'h0002);
    peek(2'd2, d);
    chk("R7 ovf cleared after", d, 16'h0003);

    // R11 vector is read-only
    wr_reg(2'd3, 16'hFFFF);
    peek(2'd3, d);
    chk("R11 vector write ignored", d, 16'h0010);
    peek(2'd0, d);
    chk("R11 enables unchanged", d, 16'hFFFF);

    // R8 flag write loads ones and zeros
    wr_reg(2'd1, 16'h8000);
    peek(2'd3, d);
    chk("R8 write loads flags", d, 16'h0024);
    wr_reg(2'd1, 16'h0000);
    peek(2'd3, d);
    chk("R8 write zero clears", d, 16'h0000);
    chk("R10 irq low", {15'd0, irq}, 16'd0);

    // R1 reset mid-run
    wr_reg(2'd1, 16'h00FF);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    peek(2'd1, d);
    chk("R1 reset clears flags", d, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule